// File: doc/BRIEF.md
# DMA Channel Address Update Unit

This block keeps the source and destination addresses of one DMA channel. After a side of a transfer has been issued, that side's address moves to the next access address. Each side has its own mode, which is fixed, increment or decrement. The step is one for byte transfers and two for word transfers. A shared repeat-area size, enabled separately for each side, keeps the upper address bits constant so that the low bits wrap inside a window of 2^N bytes.

A 16-bit CPU port writes and reads both addresses and a control word. The address can change between the two halves of a longword read. To keep such a read coherent, reading an upper half latches the whole 32-bit address. The lower half that follows is then served from that latch. While the channel is busy, the block drops CPU writes to its address registers.

Top module: `dma_addr_unit`

## Requirements
- R1: After reset, both addresses, the control word and the read snapshot are all zero.
- R2: Control bits [1:0] hold the source mode. The values 00 and 01 keep the address fixed, 10 increments it and 11 decrements it.
- R3: Control bits [3:2] hold the destination mode. It uses the same encoding as the source mode and is independent of it.
- R4: Control bit 4 selects the data size. The step is 1 when the bit is 0 and 2 when the bit is 1.
- R5: An address changes only on the clock edge where its done pulse (`src_done_i` or `dst_done_i`) is high, and it is visible from the next cycle. Both pulses in the same cycle update both sides.
- R6: Control bits [9:5] hold the repeat size N, and bits 10 and 11 enable the repeat area for source and destination respectively. For an enabled side with N from 1 to 16, the address bits at position N and above stay constant and the low N bits wrap modulo 2^N. N = 0 or N > 16 disables the repeat area.
- R7: Outside a repeat area, incrementing and decrementing wrap modulo 2^32.
- R8: Reading word 0 (source upper) or word 2 (destination upper) returns the live upper half and latches the full address. The access that immediately follows, if it reads the lower word of the same side, returns the latched lower half. Any other access discards the latch.
- R9: While `busy_i` is high, writes to words 0 to 3 are ignored. The control word at word 4 stays writable.
- R10: CPU word map: 0 = source upper, 1 = source lower, 2 = destination upper, 3 = destination lower, 4 = control (all 16 bits read back), 5 to 7 read as zero. An accepted address write in the same cycle as a done pulse takes priority over the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_sel_i | input | 1 | CPU access strobe, one access per cycle |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 3 | Word index |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data (combinational) |
| busy_i | input | 1 | Transfer in progress |
| src_done_i | input | 1 | Source access issued (one-cycle pulse) |
| dst_done_i | input | 1 | Destination access issued (one-cycle pulse) |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |

## Verification
Address outputs come from registers. A done pulse or write applied in one cycle shows on `src_addr_o` and `dst_addr_o` one edge later. The bench drives inputs after a falling edge and compares the addresses shortly after the next rising edge. Read data is combinational on the current state, so it is compared before the edge that completes the read. The snapshot is taken at that edge, which is why a lower-half read in the following cycle must return the value sampled at the upper-half read, even when a done pulse fell between them.

// File: rtl/dma_addr_pkg.sv
`timescale 1ns/1ps
package dma_addr_pkg;
  parameter int DATA_W    = 16;
  parameter int ADDR_W    = 2 * DATA_W;
  parameter int SEL_W     = 3;
  parameter int RPT_MAX   = 16;
  parameter int RPT_W     = $clog2(RPT_MAX + 1);
  parameter int NUM_SIDES = 2;

  typedef enum logic [1:0] {
    AM_FIX0 = 2'b00,
    AM_FIX1 = 2'b01,
    AM_INC  = 2'b10,
    AM_DEC  = 2'b11
  } addr_mode_e;

  localparam logic [SEL_W-1:0] REG_SRC_HI = 3'd0;
  localparam logic [SEL_W-1:0] REG_SRC_LO = 3'd1;
  localparam logic [SEL_W-1:0] REG_DST_HI = 3'd2;
  localparam logic [SEL_W-1:0] REG_DST_LO = 3'd3;
  localparam logic [SEL_W-1:0] REG_CTRL   = 3'd4;

  // control word bit positions
  localparam int CB_SMODE = 0;
  localparam int CB_DMODE = 2;
  localparam int CB_SIZE  = 4;
  localparam int CB_RPTN  = 5;
  localparam int CB_RSRC  = 10;
  localparam int CB_RDST  = 11;
endpackage

// File: rtl/dma_addr_next.sv
`timescale 1ns/1ps
module dma_addr_next
  import dma_addr_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_i,
  input  addr_mode_e        mode_i,
  input  logic              size_i,
  input  logic [RPT_W-1:0]  rpt_n_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] step, sum, mask;
  logic              rpt_on;

  always_comb begin
    step   = size_i ? ADDR_W'(2) : ADDR_W'(1);
    rpt_on = (rpt_n_i != '0) && (int'(rpt_n_i) <= RPT_MAX);
    mask   = rpt_on ? ~({ADDR_W{1'b1}} << rpt_n_i) : {ADDR_W{1'b1}};
    unique case (mode_i)
      AM_INC:  sum = cur_i + step;
      AM_DEC:  sum = cur_i - step;
      default: sum = cur_i;
    endcase
    // bits outside the window keep the current value
    nxt_o = (cur_i & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/dma_addr_reg.sv
`timescale 1ns/1ps
module dma_addr_reg
  import dma_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  addr_mode_e        mode_i,
  input  logic              size_i,
  input  logic [RPT_W-1:0]  rpt_n_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, nxt;
  logic              wr_ok;

  assign wr_ok  = (wr_hi_i | wr_lo_i) & ~busy_i;
  assign addr_o = addr_q;

  dma_addr_next u_next (
    .cur_i  (addr_q),
    .mode_i (mode_i),
    .size_i (size_i),
    .rpt_n_i(rpt_n_i),
    .nxt_o  (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (wr_ok) begin
      if (wr_hi_i) addr_q[ADDR_W-1:DATA_W] <= wdata_i;
      if (wr_lo_i) addr_q[DATA_W-1:0]      <= wdata_i;
    end else if (done_i) begin
      addr_q <= nxt;
    end
  end

  p_fixed_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !mode_i[1] && !wr_ok) |=> $stable(addr_q));

  p_busy_wr_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (wr_hi_i || wr_lo_i) && !done_i) |=> $stable(addr_q));

  p_rpt_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_ok && rpt_n_i != '0 && int'(rpt_n_i) <= RPT_MAX)
      |=> ((addr_q >> $past(rpt_n_i)) == ($past(addr_q) >> $past(rpt_n_i))));

  p_inc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_ok && mode_i == AM_INC && rpt_n_i == '0)
      |=> (addr_q - $past(addr_q)) == ($past(size_i) ? ADDR_W'(2) : ADDR_W'(1)));
endmodule

// File: rtl/dma_addr_snap.sv
`timescale 1ns/1ps
module dma_addr_snap
  import dma_addr_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                acc_i,
  input  logic [NUM_SIDES-1:0]                rd_hi_i,
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0]    addr_i,
  output logic [ADDR_W-1:0]                   snap_o,
  output logic                                vld_o,
  output logic                                side_o
);
  logic [ADDR_W-1:0] snap_q;
  logic              vld_q, side_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      vld_q  <= 1'b0;
      side_q <= 1'b0;
    end else if (acc_i) begin
      vld_q <= |rd_hi_i;
      if (|rd_hi_i) begin
        side_q <= rd_hi_i[1];
        snap_q <= rd_hi_i[1] ? addr_i[1] : addr_i[0];
      end
    end
  end

  assign snap_o = snap_q;
  assign vld_o  = vld_q;
  assign side_o = side_q;

  p_snap_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_hi_i));
endmodule

// File: rtl/dma_addr_unit.sv
`timescale 1ns/1ps
module dma_addr_unit
  import dma_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_sel_i,
  input  logic              cpu_we_i,
  input  logic [2:0]        cpu_addr_i,
  input  logic [15:0]       cpu_wdata_i,
  output logic [15:0]       cpu_rdata_o,
  input  logic              busy_i,
  input  logic              src_done_i,
  input  logic              dst_done_i,
  output logic [31:0]       src_addr_o,
  output logic [31:0]       dst_addr_o
);
  logic [DATA_W-1:0]                  ctrl_q;
  logic [NUM_SIDES-1:0][ADDR_W-1:0]   side_addr;
  logic [NUM_SIDES-1:0]               rd_hi, done;
  logic [ADDR_W-1:0]                  snap;
  logic                               snap_vld, snap_side;
  logic                               rd_acc;

  assign rd_acc = cpu_sel_i & ~cpu_we_i;
  assign done   = {dst_done_i, src_done_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           ctrl_q <= '0;
    else if (cpu_sel_i && cpu_we_i && cpu_addr_i == REG_CTRL) ctrl_q <= cpu_wdata_i;
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [SEL_W-1:0] HI_IDX = SEL_W'(2 * s);
    localparam logic [SEL_W-1:0] LO_IDX = SEL_W'(2 * s + 1);
    localparam int MB = (s == 0) ? CB_SMODE : CB_DMODE;
    localparam int RB = (s == 0) ? CB_RSRC : CB_RDST;
    logic             wr_hi, wr_lo;
    logic [RPT_W-1:0] rpt_n;

    assign wr_hi    = cpu_sel_i & cpu_we_i & (cpu_addr_i == HI_IDX);
    assign wr_lo    = cpu_sel_i & cpu_we_i & (cpu_addr_i == LO_IDX);
    assign rd_hi[s] = rd_acc & (cpu_addr_i == HI_IDX);
    assign rpt_n    = ctrl_q[RB] ? ctrl_q[CB_RPTN +: RPT_W] : '0;

    dma_addr_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .busy_i (busy_i),
      .wr_hi_i(wr_hi),
      .wr_lo_i(wr_lo),
      .wdata_i(cpu_wdata_i),
      .done_i (done[s]),
      .mode_i (addr_mode_e'(ctrl_q[MB +: 2])),
      .size_i (ctrl_q[CB_SIZE]),
      .rpt_n_i(rpt_n),
      .addr_o (side_addr[s])
    );
  end

  dma_addr_snap u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (cpu_sel_i),
    .rd_hi_i(rd_hi),
    .addr_i (side_addr),
    .snap_o (snap),
    .vld_o  (snap_vld),
    .side_o (snap_side)
  );

  always_comb begin
    unique case (cpu_addr_i)
      REG_SRC_HI: cpu_rdata_o = side_addr[0][ADDR_W-1:DATA_W];
      REG_SRC_LO: cpu_rdata_o = (snap_vld && !snap_side) ? snap[DATA_W-1:0]
                                                         : side_addr[0][DATA_W-1:0];
      REG_DST_HI: cpu_rdata_o = side_addr[1][ADDR_W-1:DATA_W];
      REG_DST_LO: cpu_rdata_o = (snap_vld && snap_side) ? snap[DATA_W-1:0]
                                                        : side_addr[1][DATA_W-1:0];
      REG_CTRL:   cpu_rdata_o = ctrl_q;
      default:    cpu_rdata_o = '0;
    endcase
  end

  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];

  p_coherent_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi[0] ##1 (rd_acc && cpu_addr_i == REG_SRC_LO))
      |-> cpu_rdata_o == $past(side_addr[0][DATA_W-1:0]));

  p_coherent_dst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi[1] ##1 (rd_acc && cpu_addr_i == REG_DST_LO))
      |-> cpu_rdata_o == $past(side_addr[1][DATA_W-1:0]));

  p_ctrl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_sel_i && cpu_we_i && cpu_addr_i == REG_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_dma_addr_unit.sv
`timescale 1ns/1ps
module tb_dma_addr_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 0, we = 0, busy = 0, sd = 0, dd = 0;
  logic [2:0]  adr = '0;
  logic [15:0] wd = '0, rd;
  logic [31:0] sa_o, da_o;
  int          n_chk = 0, n_fail = 0;

  // bench model
  logic [31:0] m_sa = 0, m_da = 0, m_snap = 0;
  logic [15:0] m_ctrl = 0;
  bit          m_vld = 0, m_side = 0;

  always #5 clk = ~clk;

  dma_addr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_sel_i(sel), .cpu_we_i(we), .cpu_addr_i(adr),
    .cpu_wdata_i(wd), .cpu_rdata_o(rd), .busy_i(busy), .src_done_i(sd), .dst_done_i(dd),
    .src_addr_o(sa_o), .dst_addr_o(da_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] a, logic [1:0] m, bit sz, int n);
    longint st = sz ? 2 : 1;
    longint la = longint'(a);
    if (!m[1]) return a;
    if (n >= 1 && n <= 16) begin
      longint w   = longint'(1) << n;
      longint off = la % w;
      off = m[0] ? (off - st + 4 * w) % w : (off + st) % w;
      return 32'(la - (la % w) + off);
    end
    return m[0] ? a - 32'(st) : a + 32'(st);
  endfunction

  function automatic logic [15:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_sa[31:16];
      3'd1: return (m_vld && !m_side) ? m_snap[15:0] : m_sa[15:0];
      3'd2: return m_da[31:16];
      3'd3: return (m_vld && m_side) ? m_snap[15:0] : m_da[15:0];
      3'd4: return m_ctrl;
      default: return 16'h0;
    endcase
  endfunction

  // one bus cycle: drive after negedge, check read before edge, check addresses after edge
  task automatic step(bit s, bit w, logic [2:0] a, logic [15:0] d, bit p_s, bit p_d, string tag);
    logic [31:0] sa0, da0;
    int ns, nd;
    @(negedge clk);
    sel = s; we = w; adr = a; wd = d; sd = p_s; dd = p_d;
    #1;
    if (s && !w) chk({tag, " rdata"}, {16'h0, rd}, {16'h0, exp_rd(a)});
    sa0 = m_sa; da0 = m_da;
    ns = m_ctrl[10] ? int'(m_ctrl[9:5]) : 0;
    nd = m_ctrl[11] ? int'(m_ctrl[9:5]) : 0;
    if (p_s) m_sa = nxt(sa0, m_ctrl[1:0], m_ctrl[4], ns);
    if (p_d) m_da = nxt(da0, m_ctrl[3:2], m_ctrl[4], nd);
    if (s && w) begin
      if (!busy) begin
        if (a == 0) m_sa = {d, sa0[15:0]};
        if (a == 1) m_sa = {sa0[31:16], d};
        if (a == 2) m_da = {d, da0[15:0]};
        if (a == 3) m_da = {da0[31:16], d};
      end
      if (a == 4) m_ctrl = d;
    end
    if (s) begin
      if (!w && (a == 0 || a == 2)) begin
        m_vld = 1; m_side = (a == 2); m_snap = (a == 2) ? da0 : sa0;
      end else m_vld = 0;
    end
    @(posedge clk); #1;
    chk({tag, " src"}, sa_o, m_sa);
    chk({tag, " dst"}, da_o, m_da);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, 16'h0, 0, 0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 src reset", sa_o, 32'h0);
    chk("R1 dst reset", da_o, 32'h0);
    rst_n = 1'b1;
    step(1, 0, 3'd4, 0, 0, 0, "R1 ctrl");
    step(1, 0, 3'd1, 0, 0, 0, "R1 snap");

    // R2 R4 byte increment of source
    step(1, 1, 3'd0, 16'h0000, 0, 0, "R10 wr");
    step(1, 1, 3'd1, 16'h1000, 0, 0, "R10 wr");
    step(1, 1, 3'd4, 16'h0002, 0, 0, "R2 ctrl");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R2 inc");
    chk("R4 byte step", sa_o, 32'h0000_1003);

    // R3 R5 R7 fixed source (01), word decrement destination, both pulses
    step(1, 1, 3'd4, 16'h001D, 0, 0, "R3 ctrl");
    step(0, 0, 0, 0, 1, 1, "R5 both");
    chk("R7 dec wrap", da_o, 32'hFFFF_FFFE);
    chk("R2 fixed 01", sa_o, 32'h0000_1003);

    // R7 increment wrap
    step(1, 1, 3'd0, 16'hFFFF, 0, 0, "R7 wr");
    step(1, 1, 3'd1, 16'hFFFF, 0, 0, "R7 wr");
    step(1, 1, 3'd4, 16'h0002, 0, 0, "R7 ctrl");
    step(0, 0, 0, 0, 1, 0, "R7 inc");
    chk("R7 inc wrap", sa_o, 32'h0);

    // R6 repeat N=4 word increment on source only
    step(1, 1, 3'd0, 16'h1234, 0, 0, "R6 wr");
    step(1, 1, 3'd1, 16'h567E, 0, 0, "R6 wr");
    step(1, 1, 3'd4, 16'h049A, 0, 0, "R6 ctrl");
    step(0, 0, 0, 0, 1, 0, "R6 rpt");
    chk("R6 window wrap", sa_o, 32'h1234_5670);
    // R6 N=17 disables
    step(1, 1, 3'd4, {4'h0, 1'b0, 1'b1, 5'd17, 5'b10010}, 0, 0, "R6 ctrl");
    step(0, 0, 0, 0, 1, 0, "R6 off");
    chk("R6 n17 off", sa_o, 32'h1234_5672);
    // R6 N=16 decrement across zero
    step(1, 1, 3'd1, 16'h0000, 0, 0, "R6 wr");
    step(1, 1, 3'd4, {4'h0, 1'b0, 1'b1, 5'd16, 5'b00011}, 0, 0, "R6 ctrl");
    step(0, 0, 0, 0, 1, 0, "R6 dec");
    chk("R6 n16 dec", sa_o, 32'h1234_FFFF);

    // R9 writes ignored while busy
    busy = 1;
    step(1, 1, 3'd0, 16'hDEAD, 0, 0, "R9 wr");
    step(1, 1, 3'd3, 16'hBEEF, 0, 0, "R9 wr");
    step(1, 0, 3'd0, 0, 0, 0, "R9 rd");
    busy = 0;

    // R10 write priority over done
    step(1, 1, 3'd4, 16'h0002, 0, 0, "R10 ctrl");
    step(1, 1, 3'd1, 16'h0100, 1, 0, "R10 prio");
    chk("R10 write wins", sa_o, 32'h1234_0100);

    // R8 coherent read with update between halves
    step(1, 0, 3'd0, 0, 1, 0, "R8 hi");
    step(1, 0, 3'd1, 0, 0, 0, "R8 lo");
    step(1, 0, 3'd1, 0, 0, 0, "R8 live");
    step(1, 0, 3'd2, 0, 0, 1, "R8 dhi");
    step(1, 0, 3'd3, 0, 0, 0, "R8 dlo");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom_range(0, 9));
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [15:0] d = 16'($urandom);
      bit ps = bit'($urandom_range(0, 1));
      bit pd = bit'($urandom_range(0, 1));
      if (($urandom_range(0, 15)) == 0) busy = ~busy;
      if (op == 0) begin
        d[9:5] = 5'($urandom_range(0, 18));
        step(1, 1, 3'd4, d, ps, pd, "R6 rnd");
      end else if (op <= 2)
        step(1, 1, a, d, ps, pd, "R10 rnd");
      else if (op <= 5)
        step(1, 0, a, 0, ps, pd, "R8 rnd");
      else
        step(0, 0, 0, 0, ps, pd, "R5 rnd");
    end
    busy = 0;
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule